// File: doc/BRIEF.md
# Two-Thread Precision-Squeezing MAC Element

This processing element sits in an output-stationary systolic array. It serves two independent dot-product threads on one shared 8-bit by 8-bit multiply-accumulate resource. On every clock edge it takes one activation/weight pair from each thread and updates one signed accumulator per thread. The element never stalls, so it retires one MAC per thread per cycle. That is twice the throughput of a single-thread element.

A thread needs the multiplier only when it is valid and both of its operands are nonzero. When only one thread needs it, that thread gets an exact full-width product. When both threads need it in the same cycle, the element does not delay either one. Instead it squeezes each operand down to four significant bits, so that both products fit the shared datapath:
- An operand whose upper four bits are zero is used exactly.
- A wider operand is rounded to its top four bits, and the product is scaled back up.

A per-thread flag marks each cycle in which reduced precision was applied. Activations move east and weights move south, each delayed by one register stage.

Top module: `smt2_mac_pe`

## Requirements
- R1: While `rst_n` is low, both accumulators, both precision flags and all forwarded operand and valid outputs are zero.
- R2: `actOut*`, `wgtOut*` and `vldOut*` equal the thread's `actIn*`, `wgtIn*` and `vldIn*` sampled at the previous rising edge.
- R3: A thread whose valid input is 0, or whose activation or weight is zero, leaves its accumulator unchanged at the next edge.
- R4: When only one thread needs the multiplier, that thread's accumulator grows by the exact product of the activation and the weight. The activation is read as unsigned 8-bit and the weight as two's-complement 8-bit. The thread's flag stays low.
- R5: When both threads need the multiplier, an operand whose bits [7:4] are all zero enters the product unchanged.
- R6: In a collision, an activation with any of bits [7:4] set is replaced by min(15, (a+8)>>4) and the product is scaled by 16.
- R7: In a collision, a weight with any of bits [7:4] set is replaced by min(7, floor((w+8)/16)) and the product is scaled by 16. When both operands are wide the scale is 256.
- R8: `lowPrec*` is high in the cycle after an edge only if that edge saw a collision in which the thread had at least one wide operand; otherwise it is low.
- R9: Both accumulators update on every edge, even during a collision, with no stall.
- R10: A high `clear` zeroes both accumulators at the next edge and discards that cycle's products. Operand forwarding continues as normal.
- R11: Accumulators are 24-bit two's-complement values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous accumulator clear |
| actIn0 | input | 8 | Thread 0 activation, unsigned |
| wgtIn0 | input | 8 | Thread 0 weight, signed |
| vldIn0 | input | 1 | Thread 0 operands valid |
| actIn1 | input | 8 | Thread 1 activation, unsigned |
| wgtIn1 | input | 8 | Thread 1 weight, signed |
| vldIn1 | input | 1 | Thread 1 operands valid |
| actOut0 | output | 8 | Thread 0 activation to the east neighbour |
| wgtOut0 | output | 8 | Thread 0 weight to the south neighbour |
| vldOut0 | output | 1 | Thread 0 valid forwarded |
| actOut1 | output | 8 | Thread 1 activation to the east neighbour |
| wgtOut1 | output | 8 | Thread 1 weight to the south neighbour |
| vldOut1 | output | 1 | Thread 1 valid forwarded |
| acc0 | output | 24 | Thread 0 partial sum |
| acc1 | output | 24 | Thread 1 partial sum |
| lowPrec0 | output | 1 | Thread 0 used reduced precision on the last edge |
| lowPrec1 | output | 1 | Thread 1 used reduced precision on the last edge |

## Verification
The properties assume that inputs are stable around each rising edge. They also assume that the forwarding and flag checks only look back to edges at which reset was already released. The stimulus changes every input on the falling edge and samples outputs on the falling edge, half a period after the updating edge. The products are kept small enough that no sum wraps. Operand patterns were picked to reach:
- each mix of narrow and wide operands;
- both saturation points of the rounding;
- an invalid thread;
- zero operands.

// File: rtl/smt2_pe_pkg.sv
package smt2_pe_pkg;
  localparam int NUM_THR = 2;

  typedef struct packed {
    logic [NUM_THR-1:0] useMul;
    logic               collide;
    logic [NUM_THR-1:0] squeezeAct;
    logic [NUM_THR-1:0] squeezeWgt;
  } peStrobe_t;
endpackage

// File: rtl/smt2_pe_ctrl.sv
module smt2_pe_ctrl
  import smt2_pe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF_W = 4
) (
  input  logic [DATA_W-1:0] act [NUM_THR],
  input  logic [DATA_W-1:0] wgt [NUM_THR],
  input  logic [NUM_THR-1:0] vld,
  output peStrobe_t          strb
);
  logic [NUM_THR-1:0] needMul;
  logic [NUM_THR-1:0] actWide;
  logic [NUM_THR-1:0] wgtWide;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign needMul[t] = vld[t] && (act[t] != '0) && (wgt[t] != '0);
    assign actWide[t] = |act[t][DATA_W-1:HALF_W];
    assign wgtWide[t] = |wgt[t][DATA_W-1:HALF_W];
  end

  always_comb begin
    strb.useMul     = needMul;
    strb.collide    = &needMul;
    strb.squeezeAct = strb.collide ? actWide : '0;
    strb.squeezeWgt = strb.collide ? wgtWide : '0;
  end
endmodule

// File: rtl/smt2_pe_datapath.sv
module smt2_pe_datapath
  import smt2_pe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF_W = 4,
  parameter int ACC_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  peStrobe_t          strb,
  input  logic [DATA_W-1:0]  act [NUM_THR],
  input  logic [DATA_W-1:0]  wgt [NUM_THR],
  input  logic [NUM_THR-1:0] vld,
  output logic [DATA_W-1:0]  actFwd [NUM_THR],
  output logic [DATA_W-1:0]  wgtFwd [NUM_THR],
  output logic [NUM_THR-1:0] vldFwd,
  output logic [ACC_W-1:0]   accOut [NUM_THR],
  output logic [NUM_THR-1:0] lowPrec
);
  localparam int SH      = DATA_W - HALF_W;
  localparam int RW      = DATA_W + 1 - SH;
  localparam int ACT_MAX = (1 << HALF_W) - 1;
  localparam int WGT_MAX = (1 << (HALF_W - 1)) - 1;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_lane
    logic        [DATA_W:0]   actSum;
    logic        [RW-1:0]     actRnd;
    logic        [HALF_W-1:0] actOp;
    logic signed [DATA_W:0]   wgtSum;
    logic signed [RW-1:0]     wgtRnd;
    logic signed [HALF_W:0]   wgtOp;
    logic signed [ACC_W-1:0]  aNarrow, wNarrow, aFull, wFull;
    logic signed [ACC_W-1:0]  prodSq, prodFull, delta;
    logic        [5:0]        shAmt;
    logic signed [ACC_W-1:0]  accQ;

    always_comb begin
      actSum = {1'b0, act[t]} + (DATA_W+1)'(1 << (SH - 1));
      actRnd = actSum[DATA_W:SH];
      actOp  = (actRnd > RW'(ACT_MAX)) ? HALF_W'(ACT_MAX) : actRnd[HALF_W-1:0];
      if (!strb.squeezeAct[t]) actOp = act[t][HALF_W-1:0];

      wgtSum = $signed({wgt[t][DATA_W-1], wgt[t]}) + $signed((DATA_W+1)'(1 << (SH - 1)));
      wgtRnd = wgtSum[DATA_W:SH];
      wgtOp  = (wgtRnd > $signed(RW'(WGT_MAX))) ? (HALF_W+1)'(WGT_MAX) : wgtRnd[HALF_W:0];
      if (!strb.squeezeWgt[t]) wgtOp = {1'b0, wgt[t][HALF_W-1:0]};

      aNarrow = $signed({{(ACC_W-HALF_W){1'b0}}, actOp});
      wNarrow = $signed({{(ACC_W-HALF_W-1){wgtOp[HALF_W]}}, wgtOp});
      aFull   = $signed({{(ACC_W-DATA_W){1'b0}}, act[t]});
      wFull   = $signed({{(ACC_W-DATA_W){wgt[t][DATA_W-1]}}, wgt[t]});
      shAmt   = (strb.squeezeAct[t] ? 6'(SH) : 6'd0) + (strb.squeezeWgt[t] ? 6'(SH) : 6'd0);
      prodSq  = (aNarrow * wNarrow) <<< shAmt;
      prodFull = aFull * wFull;

      if (!strb.useMul[t])   delta = '0;
      else if (strb.collide) delta = prodSq;
      else                   delta = prodFull;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        accQ       <= '0;
        actFwd[t]  <= '0;
        wgtFwd[t]  <= '0;
        vldFwd[t]  <= 1'b0;
        lowPrec[t] <= 1'b0;
      end else begin
        accQ       <= clear ? '0 : accQ + delta;
        actFwd[t]  <= act[t];
        wgtFwd[t]  <= wgt[t];
        vldFwd[t]  <= vld[t];
        lowPrec[t] <= strb.squeezeAct[t] | strb.squeezeWgt[t];
      end
    end

    assign accOut[t] = accQ;
  end
endmodule

// File: rtl/smt2_mac_pe.sv
module smt2_mac_pe
  import smt2_pe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF_W = 4,
  parameter int ACC_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [DATA_W-1:0] actIn0,
  input  logic [DATA_W-1:0] wgtIn0,
  input  logic              vldIn0,
  input  logic [DATA_W-1:0] actIn1,
  input  logic [DATA_W-1:0] wgtIn1,
  input  logic              vldIn1,
  output logic [DATA_W-1:0] actOut0,
  output logic [DATA_W-1:0] wgtOut0,
  output logic              vldOut0,
  output logic [DATA_W-1:0] actOut1,
  output logic [DATA_W-1:0] wgtOut1,
  output logic              vldOut1,
  output logic [ACC_W-1:0]  acc0,
  output logic [ACC_W-1:0]  acc1,
  output logic              lowPrec0,
  output logic              lowPrec1
);
  logic [DATA_W-1:0]  actArr [NUM_THR];
  logic [DATA_W-1:0]  wgtArr [NUM_THR];
  logic [DATA_W-1:0]  actFwd [NUM_THR];
  logic [DATA_W-1:0]  wgtFwd [NUM_THR];
  logic [ACC_W-1:0]   accArr [NUM_THR];
  logic [NUM_THR-1:0] vldArr, vldFwd, lowPrec;
  peStrobe_t          strb;

  assign actArr[0] = actIn0;
  assign actArr[1] = actIn1;
  assign wgtArr[0] = wgtIn0;
  assign wgtArr[1] = wgtIn1;
  assign vldArr    = {vldIn1, vldIn0};

  smt2_pe_ctrl #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_ctrl (
    .act(actArr), .wgt(wgtArr), .vld(vldArr), .strb(strb)
  );

  smt2_pe_datapath #(.DATA_W(DATA_W), .HALF_W(HALF_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .clear(clear), .strb(strb),
    .act(actArr), .wgt(wgtArr), .vld(vldArr),
    .actFwd(actFwd), .wgtFwd(wgtFwd), .vldFwd(vldFwd),
    .accOut(accArr), .lowPrec(lowPrec)
  );

  assign actOut0  = actFwd[0];
  assign actOut1  = actFwd[1];
  assign wgtOut0  = wgtFwd[0];
  assign wgtOut1  = wgtFwd[1];
  assign vldOut0  = vldFwd[0];
  assign vldOut1  = vldFwd[1];
  assign acc0     = accArr[0];
  assign acc1     = accArr[1];
  assign lowPrec0 = lowPrec[0];
  assign lowPrec1 = lowPrec[1];
endmodule

// File: rtl/smt2_mac_pe_checker.sv
module smt2_mac_pe_checker #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic [DATA_W-1:0] actIn0,
  input logic [DATA_W-1:0] wgtIn0,
  input logic              vldIn0,
  input logic [DATA_W-1:0] actIn1,
  input logic [DATA_W-1:0] wgtIn1,
  input logic              vldIn1,
  input logic [DATA_W-1:0] actOut0,
  input logic [DATA_W-1:0] wgtOut1,
  input logic [ACC_W-1:0]  acc0,
  input logic [ACC_W-1:0]  acc1,
  input logic              lowPrec0,
  input logic              lowPrec1
);
  p_fwd_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (actOut0 == $past(actIn0)));

  p_fwd_wgt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (wgtOut1 == $past(wgtIn1)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !vldIn0) |=> $stable(acc0));

  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc0 == '0 && acc1 == '0));

  p_solo_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!vldIn1 || actIn1 == '0 || wgtIn1 == '0) |=> (!lowPrec0 && !lowPrec1));

  p_flag_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lowPrec0 |-> $past(vldIn0 && vldIn1 && actIn0 != '0 && wgtIn0 != '0
                       && actIn1 != '0 && wgtIn1 != '0));
endmodule

bind smt2_mac_pe smt2_mac_pe_checker #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear),
  .actIn0(actIn0), .wgtIn0(wgtIn0), .vldIn0(vldIn0),
  .actIn1(actIn1), .wgtIn1(wgtIn1), .vldIn1(vldIn1),
  .actOut0(actOut0), .wgtOut1(wgtOut1),
  .acc0(acc0), .acc1(acc1), .lowPrec0(lowPrec0), .lowPrec1(lowPrec1)
);

// File: tb/sim_smt2_mac_pe.sv
module sim_smt2_mac_pe;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic [7:0] actIn0 = '0, wgtIn0 = '0, actIn1 = '0, wgtIn1 = '0;
  logic vldIn0 = 1'b0, vldIn1 = 1'b0;
  logic [7:0] actOut0, wgtOut0, actOut1, wgtOut1;
  logic vldOut0, vldOut1, lowPrec0, lowPrec1;
  logic [23:0] acc0, acc1;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  smt2_mac_pe u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .actIn0(actIn0), .wgtIn0(wgtIn0), .vldIn0(vldIn0),
    .actIn1(actIn1), .wgtIn1(wgtIn1), .vldIn1(vldIn1),
    .actOut0(actOut0), .wgtOut0(wgtOut0), .vldOut0(vldOut0),
    .actOut1(actOut1), .wgtOut1(wgtOut1), .vldOut1(vldOut1),
    .acc0(acc0), .acc1(acc1), .lowPrec0(lowPrec0), .lowPrec1(lowPrec1)
  );

  // a0, w0, v0, a1, w1, v1, expected acc0, expected acc1, flag0, flag1
  localparam int NV = 7;
  localparam int VEC [NV][10] = '{
    '{200,  -3, 1,   0,   50, 1,   -600,      0, 0, 0},  // R4 R3 thread1 zero act
    '{  7,   9, 1,  12,    5, 1,   -537,     60, 0, 0},  // R5 narrow collision
    '{100,  60, 1,   3,    2, 1,   5607,     66, 1, 0},  // R7 R6 both wide x256
    '{255,-128, 1, 250,  127, 1, -25113,  26946, 1, 1},  // R6 R7 saturation
    '{ 90,  40, 0,  17,  -20, 1, -25113,  26606, 0, 0},  // R3 invalid, R4 exact
    '{  0,   0, 1, 255, -128, 1, -25113,  -6034, 0, 0},  // R4 full range exact
    '{ 20,   3, 1,   5,   -1, 1, -25065,  -6034, 1, 1}   // R6 R7 mixed widths
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    // R1 reset state with busy inputs
    actIn0 = 8'd33; wgtIn0 = 8'd44; vldIn0 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 acc0", longint'($signed(acc0)), 0);
    chk("R1 acc1", longint'($signed(acc1)), 0);
    chk("R1 fwd", {actOut0, wgtOut0, vldOut0, actOut1, wgtOut1, vldOut1}, 0);
    chk("R1 flags", {lowPrec0, lowPrec1}, 0);
    vldIn0 = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      actIn0 = 8'(VEC[i][0]); wgtIn0 = 8'(VEC[i][1]); vldIn0 = VEC[i][2][0];
      actIn1 = 8'(VEC[i][3]); wgtIn1 = 8'(VEC[i][4]); vldIn1 = VEC[i][5][0];
      @(negedge clk);
      chk("R9 R11 acc0", longint'($signed(acc0)), VEC[i][6]);
      chk("R9 R11 acc1", longint'($signed(acc1)), VEC[i][7]);
      chk("R8 flag0", lowPrec0, VEC[i][8]);
      chk("R8 flag1", lowPrec1, VEC[i][9]);
      chk("R2 fwd t0", {actOut0, wgtOut0, vldOut0}, {8'(VEC[i][0]), 8'(VEC[i][1]), VEC[i][2][0]});
      chk("R2 fwd t1", {actOut1, wgtOut1, vldOut1}, {8'(VEC[i][3]), 8'(VEC[i][4]), VEC[i][5][0]});
    end

    // R10 clear during a collision: products dropped, forwarding goes on
    clear = 1'b1;
    actIn0 = 8'd99; wgtIn0 = 8'd77; vldIn0 = 1'b1;
    actIn1 = 8'd66; wgtIn1 = 8'd55; vldIn1 = 1'b1;
    @(negedge clk);
    chk("R10 acc0", longint'($signed(acc0)), 0);
    chk("R10 acc1", longint'($signed(acc1)), 0);
    chk("R10 fwd", {actOut1, wgtOut1}, {8'd66, 8'd55});
    clear = 1'b0;

    // R3 zero weight and invalid thread; R8 flags drop
    wgtIn0 = 8'd0; vldIn1 = 1'b0;
    @(negedge clk);
    chk("R3 acc0", longint'($signed(acc0)), 0);
    chk("R3 acc1", longint'($signed(acc1)), 0);
    chk("R8 flags idle", {lowPrec0, lowPrec1}, 0);

    // R4 negative exact product on thread 1 alone
    vldIn0 = 1'b0; vldIn1 = 1'b1; actIn1 = 8'd128; wgtIn1 = 8'hF1;
    @(negedge clk);
    chk("R4 acc1", longint'($signed(acc1)), -1920);
    chk("R4 flag1", lowPrec1, 0);

    // R2 output must hold last sampled value until the next edge
    actIn1 = 8'd5;
    #1;
    chk("R2 latency", actOut1, 8'd128);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule